// File: doc/BRIEF.md
# Capture/Compare Timer with Sequenced Flag Clearing

A free-running up-counter timer reached through an 8-bit register bus. A prescaler divides the clock, and the counter advances by one on each prescaler tick. Two capture inputs latch the counter value on a rising edge. Two compare registers raise events when the counter reaches them. Each compare channel drives an output pin that toggles on every match.

Five event flags live in one status register: capture 1, compare 1, overflow, capture 2 and compare 2. A flag is set by hardware. Software clears it with a two-step sequence: it first reads the status register, then reads or writes the low byte of the data register that belongs to that flag. The status read arms only the flags that were set at that moment. A second copy of the counter lets software read the count without disturbing the overflow flag.

A disable bit in the status register freezes the prescaler and the counter and holds both compare pins low. The bus stays fully usable while the timer is disabled. An input pin selects a PWM-style mode, in which a compare-2 match also raises the capture-1 flag.

Top module: `cct_timer`

## Requirements
- R1: After reset, the status register reads 00h, the capture and compare registers read 00h in every byte, and both compare pins are low.
- R2: The register addresses are: 0 counter high, 1 counter low, 2 alias high, 3 alias low, 4 capture-1 high, 5 capture-1 low, 6 capture-2 high, 7 capture-2 low, 8 compare-1 high, 9 compare-1 low, 10 compare-2 high, 11 compare-2 low, 12 status. Status bit 7 is the capture-1 flag, bit 6 the compare-1 flag, bit 5 the overflow flag, bit 4 the capture-2 flag, bit 3 the compare-2 flag and bit 2 the writable disable bit. Bits 1:0 always read 0. Read data appears on the clock edge after the read strobe.
- R3: While the timer is enabled, the counter advances once every PRESCALE clocks. A write to the counter low byte restarts both the counter and the prescaler at 0. The overflow flag sets when the counter steps from FFFFh to 0000h.
- R4: The compare flag of a channel sets on the tick at which the counter takes the value of that channel's compare register, and the channel's output pin toggles at the same time.
- R5: A rising edge on a capture input, after a two-stage synchronizer, copies the current counter value into that channel's capture register and sets its capture flag within four clocks.
- R6: A flag clears only on an access to the low byte of its own register (capture-1 low, compare-1 low, counter low, capture-2 low, compare-2 low) that follows a status read. A low-byte access without a preceding status read leaves the flag set.
- R7: A status read arms only the flags that are set when it happens. A flag that sets after that read survives the following low-byte access.
- R8: The alias counter returns the same count as the counter. Reading or writing its low byte never clears the overflow flag.
- R9: When a flag's set event and its clearing access fall in the same clock, the flag stays set.
- R10: With the disable bit at 1, the counter and prescaler hold, both compare pins are low, and every register can still be read and written.
- R11: While the PWM-mode input is high, a compare-2 match also sets the capture-1 flag.
- R12: Both compare registers read back, byte by byte, the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_in1 | input | 1 | Capture input, channel 1 |
| cap_in2 | input | 1 | Capture input, channel 2 |
| pwm_mode | input | 1 | Compare-2 match also raises the capture-1 flag |
| cmp_out1 | output | 1 | Compare-1 toggle output |
| cmp_out2 | output | 1 | Compare-2 toggle output |

## Verification
Read data is due one edge after the strobe. Counter, flag and pin effects of a tick land on the tick's own edge. A capture settles three edges after the input rises. The bench issues bus operations back to back, one per edge, from the falling edge, and samples read data at the next falling edge. It can therefore place a status read and a low-byte access on exact counter values, for example to make a clearing access coincide with a compare match. Counter-dependent checks freeze the timer first, or count whole clock cycles from the enabling write, so that the expected count follows from the number of edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [3:0] {
    A_CNT_HI  = 4'd0,
    A_CNT_LO  = 4'd1,
    A_ALT_HI  = 4'd2,
    A_ALT_LO  = 4'd3,
    A_CAP1_HI = 4'd4,
    A_CAP1_LO = 4'd5,
    A_CAP2_HI = 4'd6,
    A_CAP2_LO = 4'd7,
    A_CMP1_HI = 4'd8,
    A_CMP1_LO = 4'd9,
    A_CMP2_HI = 4'd10,
    A_CMP2_LO = 4'd11,
    A_STATUS  = 4'd12
  } reg_addr_e;

  // flag vector index; status bits [7:3] hold flag[4:0]
  localparam int F_CAP1 = 4;
  localparam int F_CMP1 = 3;
  localparam int F_OVF  = 2;
  localparam int F_CAP2 = 1;
  localparam int F_CMP2 = 0;
  localparam int NFLAG  = 5;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             tick,
  output logic             wrap
);
  localparam int PSC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PSC_W-1:0] PSC_END = PSC_W'(PRESCALE - 1);

  logic [PSC_W-1:0] psc_q;

  assign tick    = !freeze && !restart && (psc_q == PSC_END);
  assign cnt_nxt = cnt_q + 1'b1;
  assign wrap    = tick && (cnt_q == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (!freeze) begin
      psc_q <= (psc_q == PSC_END) ? '0 : psc_q + 1'b1;
      if (tick) cnt_q <= cnt_nxt;
    end
  end

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    freeze && !restart |=> $stable(cnt_q)); // R10
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0); // R3
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W = 16,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap_q,
  output logic             hit
);
  logic [SYNC:0] sh_q;

  assign hit = sh_q[SYNC-1] && !sh_q[SYNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cap_q <= '0;
    end else begin
      sh_q <= {sh_q[SYNC-1:0], pin};
      if (hit) cap_q <= cnt;
    end
  end

  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (rst)
    hit |=> cap_q == $past(cnt)); // R5
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic         arm_ld,
  input  logic [N-1:0] clr_acc,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] arm_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        if (set_ev[i])                   flag_q[i] <= 1'b1;
        else if (clr_acc[i] && arm_q[i]) flag_q[i] <= 1'b0;
        if (arm_ld)                      arm_q[i]  <= flag_q[i];
        else if (clr_acc[i])             arm_q[i]  <= 1'b0;
      end
    end

    AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      $fell(flag_q[i]) |-> $past(arm_q[i]) && $past(clr_acc[i])); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_ev[i] |=> flag_q[i]); // R9
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import tmr_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cap_in1,
  input  logic          cap_in2,
  input  logic          pwm_mode,
  output logic          cmp_out1,
  output logic          cmp_out2
);
  localparam int CNT_W = 2 * DW;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cap1_q, cap2_q, cmp1_q, cmp2_q;
  logic             tick, wrap, cap1_hit, cap2_hit, match1, match2;
  logic             dis_q, dis_nxt, tog1_q, tog2_q, tog1_nxt, tog2_nxt;
  logic             any_acc, st_rd, restart;
  logic [NFLAG-1:0] flag_q, set_ev, clr_acc;
  logic [DW-1:0]    status;

  assign any_acc = bus_rd || bus_wr;
  assign st_rd   = bus_rd && (bus_addr == A_STATUS);
  assign restart = bus_wr && (bus_addr == A_CNT_LO);
  assign dis_nxt = (bus_wr && bus_addr == A_STATUS) ? bus_wdata[2] : dis_q;

  tmr_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_cnt (
    .clk(clk), .rst(rst), .freeze(dis_q), .restart(restart),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .tick(tick), .wrap(wrap));

  tmr_capture #(.CNT_W(CNT_W)) u_cap1 (
    .clk(clk), .rst(rst), .pin(cap_in1), .cnt(cnt_q), .cap_q(cap1_q), .hit(cap1_hit));
  tmr_capture #(.CNT_W(CNT_W)) u_cap2 (
    .clk(clk), .rst(rst), .pin(cap_in2), .cnt(cnt_q), .cap_q(cap2_q), .hit(cap2_hit));

  assign match1 = tick && (cnt_nxt == cmp1_q);
  assign match2 = tick && (cnt_nxt == cmp2_q);

  always_comb begin
    set_ev          = '0;
    set_ev[F_CAP1]  = cap1_hit || (pwm_mode && match2);
    set_ev[F_CMP1]  = match1;
    set_ev[F_OVF]   = wrap;
    set_ev[F_CAP2]  = cap2_hit;
    set_ev[F_CMP2]  = match2;
    clr_acc         = '0;
    clr_acc[F_CAP1] = any_acc && (bus_addr == A_CAP1_LO);
    clr_acc[F_CMP1] = any_acc && (bus_addr == A_CMP1_LO);
    clr_acc[F_OVF]  = any_acc && (bus_addr == A_CNT_LO);
    clr_acc[F_CAP2] = any_acc && (bus_addr == A_CAP2_LO);
    clr_acc[F_CMP2] = any_acc && (bus_addr == A_CMP2_LO);
  end

  tmr_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .arm_ld(st_rd),
    .clr_acc(clr_acc), .flag_q(flag_q));

  assign status   = {flag_q, dis_q, 2'b00};
  assign tog1_nxt = tog1_q ^ match1;
  assign tog2_nxt = tog2_q ^ match2;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q    <= 1'b0;
      cmp1_q   <= '0;
      cmp2_q   <= '0;
      tog1_q   <= 1'b0;
      tog2_q   <= 1'b0;
      cmp_out1 <= 1'b0;
      cmp_out2 <= 1'b0;
    end else begin
      dis_q    <= dis_nxt;
      tog1_q   <= tog1_nxt;
      tog2_q   <= tog2_nxt;
      cmp_out1 <= tog1_nxt && !dis_nxt;
      cmp_out2 <= tog2_nxt && !dis_nxt;
      if (bus_wr) begin
        case (bus_addr)
          A_CMP1_HI: cmp1_q[CNT_W-1:DW] <= bus_wdata;
          A_CMP1_LO: cmp1_q[DW-1:0]     <= bus_wdata;
          A_CMP2_HI: cmp2_q[CNT_W-1:DW] <= bus_wdata;
          A_CMP2_LO: cmp2_q[DW-1:0]     <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CNT_HI, A_ALT_HI: bus_rdata <= cnt_q[CNT_W-1:DW];
        A_CNT_LO, A_ALT_LO: bus_rdata <= cnt_q[DW-1:0];
        A_CAP1_HI:          bus_rdata <= cap1_q[CNT_W-1:DW];
        A_CAP1_LO:          bus_rdata <= cap1_q[DW-1:0];
        A_CAP2_HI:          bus_rdata <= cap2_q[CNT_W-1:DW];
        A_CAP2_LO:          bus_rdata <= cap2_q[DW-1:0];
        A_CMP1_HI:          bus_rdata <= cmp1_q[CNT_W-1:DW];
        A_CMP1_LO:          bus_rdata <= cmp1_q[DW-1:0];
        A_CMP2_HI:          bus_rdata <= cmp2_q[CNT_W-1:DW];
        A_CMP2_LO:          bus_rdata <= cmp2_q[DW-1:0];
        A_STATUS:           bus_rdata <= status;
        default:            bus_rdata <= '0;
      endcase
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    st_rd |=> bus_rdata[1:0] == 2'b00); // R2
  AST_PINS_OFF: assert property (@(posedge clk) disable iff (rst)
    dis_q |-> !cmp_out1 && !cmp_out2); // R10
  AST_PWM_HOOK: assert property (@(posedge clk) disable iff (rst)
    pwm_mode && match2 |=> flag_q[F_CAP1]); // R11
  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    match1 && !dis_nxt |=> cmp_out1 != $past(cmp_out1)); // R4
endmodule

// File: tb/cct_timer_bench.sv
module cct_timer_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       cap_in1, cap_in2, pwm_mode;
  logic       cmp_out1, cmp_out2;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       done = 1'b0;
  logic [7:0] hi, lo, v8;
  logic [15:0] vcnt;

  always #4 clk = ~clk;

  cct_timer #(.PRESCALE(1)) u_cct_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in1(cap_in1),
    .cap_in2(cap_in2), .pwm_mode(pwm_mode), .cmp_out1(cmp_out1), .cmp_out2(cmp_out2));

  // address, write value, expected readback
  localparam logic [19:0] VEC [4] = '{
    {4'd8,  8'hA5, 8'hA5},
    {4'd9,  8'h3C, 8'h3C},
    {4'd10, 8'h5A, 8'h5A},
    {4'd11, 8'hC3, 8'hC3}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge, one edge per operation
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cap(input int ch);
    if (ch == 1) cap_in1 = 1'b1; else cap_in2 = 1'b1;
    idle(3);
    cap_in1 = 1'b0; cap_in2 = 1'b0;
    idle(6);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    cap_in1 = 0; cap_in2 = 0; pwm_mode = 0;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    rd(4'd12, v8); check("R1 status", v8, 8'h00);
    rd(4'd4, v8);  check("R1 cap1 hi", v8, 8'h00);
    rd(4'd9, v8);  check("R1 cmp1 lo", v8, 8'h00);
    check("R1 pins", {cmp_out1, cmp_out2}, 2'b00);

    // R2 reserved bits, R10 disable bit writable
    wr(4'd12, 8'hFF);
    rd(4'd12, v8); check("R2 status layout", v8, 8'h04);

    // R12 compare readback table (timer disabled)
    for (int i = 0; i < 4; i++) wr(VEC[i][19:16], VEC[i][15:8]);
    for (int i = 0; i < 4; i++) begin
      rd(VEC[i][19:16], v8); check("R12 readback", v8, VEC[i][7:0]);
    end

    // R10 freeze
    rd(4'd0, hi); rd(4'd1, lo);
    idle(10);
    rd(4'd0, v8); check("R10 frozen hi", v8, hi);
    rd(4'd1, v8); check("R10 frozen lo", v8, lo);

    // R4 compare match
    wr(4'd1, 8'h00);                    // restart counter
    wr(4'd8, 8'h00); wr(4'd9, 8'h20);
    wr(4'd10, 8'h00); wr(4'd11, 8'h30);
    wr(4'd12, 8'h00);
    idle(36);
    check("R4 pins after cmp1 match", {cmp_out1, cmp_out2}, 2'b10);
    wr(4'd12, 8'h04);
    check("R10 pins low when disabled", {cmp_out1, cmp_out2}, 2'b00);
    // R6 low access without status read keeps flag
    rd(4'd9, v8);
    rd(4'd12, v8); check("R6 no clear without status read", v8, 8'h44);
    rd(4'd9, v8);
    rd(4'd12, v8); check("R6 sequenced clear", v8, 8'h04);

    // R7 flag set after status read survives
    wr(4'd1, 8'h00); wr(4'd9, 8'hF0); wr(4'd11, 8'h10);
    wr(4'd12, 8'h00);
    rd(4'd12, v8);
    idle(30);
    wr(4'd11, 8'h10);
    wr(4'd12, 8'h04);
    rd(4'd12, v8); check("R7 late flag not cleared", v8, 8'h0C);
    rd(4'd11, v8);
    rd(4'd12, v8); check("R7 cleared after new read", v8, 8'h04);

    // R9 set wins over clear
    wr(4'd1, 8'h00); wr(4'd9, 8'h02);
    wr(4'd12, 8'h00); idle(5); wr(4'd12, 8'h04);
    wr(4'd1, 8'h00);
    wr(4'd12, 8'h00);                   // enable at edge e0
    rd(4'd12, v8);                      // e0+1, arms compare-1 flag
    rd(4'd9, v8);                       // e0+2, coincides with match
    wr(4'd12, 8'h04);
    rd(4'd12, v8); check("R9 set wins", v8, 8'h44);
    rd(4'd9, v8);
    rd(4'd12, v8); check("R9 later clear", v8, 8'h04);

    // R5 capture while frozen
    rd(4'd0, hi); rd(4'd1, lo);
    pulse_cap(1);
    rd(4'd4, v8); check("R5 cap1 hi", v8, hi);
    rd(4'd5, v8); check("R5 cap1 lo", v8, lo);
    pulse_cap(2);
    rd(4'd12, v8); check("R5 flags", v8, 8'h94);
    rd(4'd6, v8); check("R5 cap2 hi", v8, hi);
    rd(4'd7, v8); check("R5 cap2 lo", v8, lo);   // clears capture-2 (armed)
    rd(4'd5, v8);                                // clears capture-1
    rd(4'd12, v8); check("R6 capture flags cleared", v8, 8'h04);

    // R11 PWM hook
    pwm_mode = 1'b1;
    wr(4'd1, 8'h00); wr(4'd9, 8'hF0); wr(4'd11, 8'h08);
    wr(4'd12, 8'h00); idle(20); wr(4'd12, 8'h04);
    pwm_mode = 1'b0;
    rd(4'd12, v8); check("R11 pwm flag", v8, 8'h8C);
    rd(4'd5, v8); rd(4'd11, v8);
    rd(4'd12, v8); check("R11 cleared", v8, 8'h04);

    // R3 wrap and overflow flag
    wr(4'd1, 8'h00);
    wr(4'd12, 8'h00);                   // edge e0
    idle(65540);
    wr(4'd12, 8'h04);                   // edge e0+65541 still ticks
    rd(4'd0, hi); rd(4'd3, lo); vcnt = {hi, lo};
    check("R3 count after wrap", vcnt, 16'd5);
    rd(4'd12, v8); check("R3 overflow flag", {8'h00, v8 & 8'h20}, 16'h0020);
    rd(4'd3, lo); rd(4'd2, hi);
    rd(4'd12, v8); check("R8 alias keeps overflow", {8'h00, v8 & 8'h20}, 16'h0020);
    rd(4'd1, v8); check("R8 alias equals counter", v8, lo);
    rd(4'd12, v8); check("R6 counter low clears overflow", {8'h00, v8 & 8'h20}, 16'h0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule